// File: doc/BRIEF.md
# Channel Selector with Change-Triggered Divider Update

This block picks the frequency-divider word for a synthesizer from a bank of channel switches and a transmit/receive sense line. Each channel owns two preset words, one used while transmitting and one used while receiving, with the receive word offset from the transmit word by a fixed amount. The chosen word is presented on a 16-bit output, and the block raises a one-cycle update request to a separate serial loader whenever that loader should reprogram the synthesizer.

All inputs pass through two-stage synchronisers. The block keeps a snapshot of the synchronised switch pattern and of the transmit/receive state. Any difference from the snapshot refreshes it and marks an update as pending. A change of switch pattern also reloads the presets for the highest-numbered closed switch. If no switch is closed, the previous presets stay in place. A pending update is issued as a single pulse as soon as the loader is not busy. Several changes that occur before the pulse is issued produce one pulse only.

Top module: `chsel_top`

## Requirements
- R1: After reset, `div_word` is zero and `upd_req` is low. No request is raised while the synchronised inputs match the reset snapshot, which is all switches open with receive selected.
- R2: Switch input bit i low selects channel index i. When several bits are low, the highest index wins. For index i, the transmit word is TX_BASE + TX_STEP*i and the receive word is that value plus RX_OFS. The defaults are 0x0835, 0x0005 and 0x01A0.
- R3: While the stored transmit/receive state is 1, `div_word` shows the transmit word of the loaded channel. While it is 0, `div_word` shows the receive word.
- R4: When the switch pattern changes to all inputs high, the loaded words are kept. `div_word` then changes only if the transmit/receive state changes.
- R5: A switch input change reaches `div_word` at the third rising clock edge after the change. With the loader idle, `upd_req` is high in the cycle after that edge.
- R6: A change of `tx_sel` alone produces exactly one request, and `div_word` swaps between the transmit and receive words.
- R7: `upd_req` is never high for two cycles in a row.
- R8: No request is issued in the cycle after `ld_busy` is high. A pending request is issued in the cycle after the first cycle in which `ld_busy` is low.
- R9: Any number of changes made while a request is pending, including changes made while the loader is busy, produce a single request. That request carries the final word.
- R10: A switch pattern change that leaves the same winning channel still raises a request, and `div_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_n | input | NCH | Channel switches, active low, bit i = channel index i |
| tx_sel | input | 1 | 1 = transmit, 0 = receive |
| ld_busy | input | 1 | Serial loader busy |
| div_word | output | 16 | Selected divider word (registered) |
| upd_req | output | 1 | One-cycle request to reprogram the synthesizer |

## Verification
A stale or corrupted switch snapshot shows at the ports within about four cycles of the next input step. It appears as either a missing request or an extra one, counted over a fixed window after each step. A wrong preset or a wrong winner shows as a mismatched `div_word` at the end of that window. The sweep over all switch patterns reaches every winning index and every combination of lower switches. A pending flag that is lost or duplicated under `ld_busy` changes the request count in the busy and merge tests.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  parameter int unsigned CH_DW = 16;

  typedef logic [CH_DW-1:0] div_t;

  typedef struct packed {
    div_t tx;
    div_t rx;
  } div_pair_t;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/chsel_prio.sv
module chsel_prio #(
  parameter int unsigned N  = 10,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  sel_n,
  output logic [IW-1:0] idx,
  output logic          hit
);
  // ascending scan: a later match overrides an earlier one
  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!sel_n[i]) begin
        idx = IW'(i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chsel_rom.sv
module chsel_rom
  import chsel_pkg::*;
#(
  parameter int unsigned N       = 10,
  parameter int unsigned IW      = 4,
  parameter div_t        TX_BASE = 16'h0835,
  parameter div_t        TX_STEP = 16'h0005,
  parameter div_t        RX_OFS  = 16'h01A0
) (
  input  logic [IW-1:0] idx,
  output div_pair_t     pair
);
  localparam int unsigned DEPTH = 1 << IW;

  div_pair_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g < N) begin : g_used
      localparam div_t TXV = div_t'(TX_BASE + TX_STEP * g);
      assign tbl[g].tx = TXV;
      assign tbl[g].rx = div_t'(TXV + RX_OFS);
    end else begin : g_pad
      assign tbl[g] = '0;
    end
  end

  assign pair = tbl[idx];
endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
#(
  parameter int unsigned NCH     = 10,
  parameter div_t        TX_BASE = 16'h0835,
  parameter div_t        TX_STEP = 16'h0005,
  parameter div_t        RX_OFS  = 16'h01A0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   sw_n,
  input  logic             tx_sel,
  input  logic             ld_busy,
  output logic [CH_DW-1:0] div_word,
  output logic             upd_req
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] sw_s;
  logic           tr_s;
  logic [NCH-1:0] sw_snap;
  logic           tr_snap;
  logic [IW-1:0]  win_idx;
  logic           win_hit;
  div_pair_t      preset;
  div_t           tx_q, rx_q, tx_nx, rx_nx, div_q;
  logic           pend_q, req_q;
  logic           sw_chg, tr_chg, issue;

  chsel_sync #(.W(NCH), .RST_VAL({NCH{1'b1}})) u_sw_sync (
    .clk(clk), .rst(rst), .d(sw_n), .q(sw_s)
  );

  chsel_sync #(.W(1), .RST_VAL(1'b0)) u_tr_sync (
    .clk(clk), .rst(rst), .d(tx_sel), .q(tr_s)
  );

  chsel_prio #(.N(NCH), .IW(IW)) u_prio (
    .sel_n(sw_s), .idx(win_idx), .hit(win_hit)
  );

  chsel_rom #(
    .N(NCH), .IW(IW), .TX_BASE(TX_BASE), .TX_STEP(TX_STEP), .RX_OFS(RX_OFS)
  ) u_rom (
    .idx(win_idx), .pair(preset)
  );

  assign sw_chg = (sw_s != sw_snap);
  assign tr_chg = (tr_s != tr_snap);
  assign issue  = pend_q && !ld_busy && !req_q;

  always_comb begin
    tx_nx = tx_q;
    rx_nx = rx_q;
    if (sw_chg && win_hit) begin
      tx_nx = preset.tx;
      rx_nx = preset.rx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_snap <= '1;
      tr_snap <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      div_q   <= '0;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      sw_snap <= sw_s;
      tr_snap <= tr_s;
      tx_q    <= tx_nx;
      rx_q    <= rx_nx;
      div_q   <= tr_s ? tx_nx : rx_nx;
      pend_q  <= sw_chg || tr_chg || (pend_q && !issue);
      req_q   <= issue;
    end
  end

  assign div_word = div_q;
  assign upd_req  = req_q;
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk
  import chsel_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic ld_busy,
  input logic upd_req,
  input logic pend_q,
  input logic tr_snap,
  input div_t div_word,
  input div_t tx_q,
  input div_t rx_q
);
  p_req_gap_r7: assert property (@(posedge clk) disable iff (rst)
    upd_req |=> !upd_req);

  p_busy_block_r8: assert property (@(posedge clk) disable iff (rst)
    ld_busy |=> !upd_req);

  p_req_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    upd_req |-> $past(pend_q));

  p_word_moves_only_on_change_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_word) |-> pend_q);

  p_tx_view_r3: assert property (@(posedge clk) disable iff (rst)
    tr_snap |-> (div_word == tx_q));

  p_rx_view_r3: assert property (@(posedge clk) disable iff (rst)
    !tr_snap |-> (div_word == rx_q));
endmodule

bind chsel_top chsel_chk u_chk (
  .clk(clk), .rst(rst), .ld_busy(ld_busy), .upd_req(upd_req),
  .pend_q(pend_q), .tr_snap(tr_snap), .div_word(div_word),
  .tx_q(tx_q), .rx_q(rx_q)
);

// File: tb/sim_chsel_top.sv
module sim_chsel_top;
  localparam int NCH = 10;
  localparam logic [15:0] BASE = 16'h0835;
  localparam logic [15:0] STEP = 16'h0005;
  localparam logic [15:0] ROFS = 16'h01A0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] sw_n = '1;
  logic tx_sel = 1'b0;
  logic ld_busy = 1'b0;
  logic [15:0] div_word;
  logic upd_req;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  logic prev_req = 1'b0;
  logic [15:0] etx = '0;
  logic [15:0] erx = '0;

  always #10 clk = ~clk;

  chsel_top #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .sw_n(sw_n), .tx_sel(tx_sel), .ld_busy(ld_busy),
    .div_word(div_word), .upd_req(upd_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // advance n cycles, sample at negedge, count request pulses
  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (upd_req) pulses++;
      if (upd_req && prev_req) chk("R7 back-to-back", 1, 0);
      prev_req = upd_req;
    end
  endtask

  function automatic void expect_pat(input logic [NCH-1:0] p);
    for (int i = 0; i < NCH; i++) begin
      if (p[i]) begin
        etx = BASE + STEP * i;
        erx = BASE + STEP * i + ROFS;
      end
    end
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pulses = 0;
    run(8);
    chk("R1 word after reset", div_word, 0);
    chk("R1 no request at idle", pulses, 0);

    // R5 latency: change at negedge, word at 3rd edge, req after
    sw_n = ~10'b0000000100;
    pulses = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 word not yet", div_word, 0);
    @(negedge clk);
    chk("R5 word at 3rd edge", div_word, BASE + STEP * 2 + ROFS);
    chk("R5 req not yet", upd_req, 0);
    @(negedge clk);
    chk("R5 req after", upd_req, 1);
    prev_req = 1'b1;
    run(6);
    etx = BASE + STEP * 2; erx = etx + ROFS;

    // R2 sweep of every switch pattern, R3 via tx_sel from pattern parity
    for (int p = 1; p < (1 << NCH); p++) begin
      sw_n = ~NCH'(p);
      tx_sel = p[0] ^ p[3];
      pulses = 0;
      run(8);
      expect_pat(NCH'(p));
      chk("R2/R3 swept word", div_word, tx_sel ? etx : erx);
      chk("R5 one pulse per change", pulses, 1);
    end

    // R6 tx_sel toggle alone
    sw_n = ~10'b0001000000; tx_sel = 1'b1; run(10);
    etx = BASE + STEP * 6; erx = etx + ROFS;
    chk("R3 tx word", div_word, etx);
    pulses = 0; tx_sel = 1'b0; run(8);
    chk("R6 rx word after toggle", div_word, erx);
    chk("R6 one pulse", pulses, 1);

    // R10 lower switch added, same winner
    pulses = 0; sw_n = ~10'b0001000010; run(8);
    chk("R10 word unchanged", div_word, erx);
    chk("R10 pulse", pulses, 1);

    // R4 all open keeps words
    pulses = 0; sw_n = '1; run(8);
    chk("R4 rx kept", div_word, erx);
    chk("R4 pulse on release", pulses, 1);
    pulses = 0; tx_sel = 1'b1; run(8);
    chk("R4 tx kept", div_word, etx);

    // R8 busy holds request
    ld_busy = 1'b1; pulses = 0;
    sw_n = ~10'b1000000000; run(12);
    chk("R8 none while busy", pulses, 0);
    ld_busy = 1'b0; run(1);
    chk("R8 issued after release", upd_req, 1);
    prev_req = 1'b1;
    run(6);

    // R9 merge several changes while busy
    ld_busy = 1'b1; pulses = 0;
    sw_n = ~10'b0000001000; run(6);
    tx_sel = 1'b0; run(6);
    sw_n = ~10'b0000100000; run(6);
    ld_busy = 1'b0; run(8);
    chk("R9 single pulse", pulses, 1);
    chk("R9 final word", div_word, BASE + STEP * 5 + ROFS);

    // R1 reset again
    rst = 1'b1; run(2); rst = 1'b0; sw_n = '1; tx_sel = 1'b0;
    pulses = 0; run(8);
    chk("R1 word after second reset", div_word, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule